// File: doc/BRIEF.md
# Channel Select Gate

This block lets several interface channels hang off one shared host control bus. A select input chooses the channel. While the channel is selected, the host control inputs reach the internal control logic. These inputs are reset, two active-low power commands and a clock level. The three bidirectional data lines between host side and card side are also free to carry traffic. While the channel is deselected, the control values seen by the internal logic are frozen. The data lines are parked idle-high. The status and ready outputs have their output enables dropped, so that another channel can drive the shared wires.

Fault sensing and card-presence sensing never depend on the select input. A card removal or a fault during a card session raises a deactivation request whether or not the channel is selected.

Each data line has a small direction arbiter. In its neutral state, the first falling edge seen on either side makes that side the driver. The other side then follows it. The line returns to neutral on the driving side's rising edge.

Top module: `chansel_gate`

## Requirements
- R1: While `sel` is sampled high at a clock edge, `ctl_out` after that edge equals `ctl_in` sampled at that edge. The bit positions are 0 reset, 1 power command A (active low), 2 power command B (active low) and 3 clock level.
- R2: At every edge where `sel` is sampled low, `ctl_out` keeps its value, so it holds what was captured at the last selected edge. Changes on `ctl_in` while deselected have no effect.
- R3: At the first edge with `sel` high again, `ctl_out` takes the live `ctl_in` value.
- R4: After synchronous active-low reset, `ctl_out` is 4'b0110 (reset asserted, both power commands off, clock low). All data outputs are high, `deact_req` is 0 and every line is neutral.
- R5: When a line is neutral, selected, and a falling edge on `host_din[i]` is sampled at an edge, then from that edge on `card_dout[i]` follows `host_din[i]` and `host_dout[i]` stays high.
- R6: The mirror of R5 holds for a falling edge on `card_din[i]`: `host_dout[i]` follows `card_din[i]` and `card_dout[i]` stays high.
- R7: A rising edge on the driving side returns the line to neutral. Both outputs are then high, and either side may claim the line next.
- R8: If both sides of a neutral line fall at the same sampled edge, the host side wins.
- R9: While `sel` is low, both data outputs of every line are high. Any transfer in progress is forced to neutral. Falling edges are ignored and are not acted on after reselection.
- R10: `status_oe` and `ready_oe` equal `sel`. `ready_o` equals `rdy_in`.
- R11: A session is active when either power command in `ctl_out` is low. Outside a session `status_o` equals `pres`. Inside a session `status_o` is `pres & ~fault`.
- R12: `deact_req` is registered. After each edge it is 1 exactly when, at that edge, a session was active and `fault` was high or `pres` was low. This holds independently of `sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Channel select, synchronous to clk |
| ctl_in | input | 4 | Host control inputs {clock, pwr B_n, pwr A_n, reset} |
| ctl_out | output | 4 | Control values driving the internal logic |
| host_din | input | 3 | Host-side data line levels |
| host_dout | output | 3 | Host-side data line drive (1 = release high) |
| card_din | input | 3 | Card-side data line levels |
| card_dout | output | 3 | Card-side data line drive (1 = release high) |
| pres | input | 1 | Card present (active high) |
| fault | input | 1 | Fault detected (active high) |
| rdy_in | input | 1 | Internal ready flag |
| status_o | output | 1 | Status/presence output value |
| status_oe | output | 1 | Status output enable |
| ready_o | output | 1 | Ready output value |
| ready_oe | output | 1 | Ready output enable |
| deact_req | output | 1 | Deactivation request to the sequencer |

## Verification
The assertions assume that `sel`, `ctl_in`, the data line levels, `pres` and `fault` are synchronous to `clk` and settle before each rising edge. They also assume that a line's falling edge is one level change between two sampled edges, not a pulse shorter than a cycle. The stimulus keeps to this by changing every input only on the falling clock edge, and by holding each level for at least one full cycle. The line tests keep the non-driving side high while a transfer runs, so that the edge detectors see only the edges each scenario intends.

// File: rtl/chansel_pkg.sv
// Shared types for the channel select gate.
package chansel_pkg;

    // Direction state of one data line arbiter.
    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,  // neutral, both sides released
        LN_H2C  = 2'd1,  // host side drives card side
        LN_C2H  = 2'd2   // card side drives host side
    } ln_dir_e;

endpackage

// File: rtl/chansel_ctrl_hold.sv
// Control hold register.
// Passes the host control vector to the internal logic through one register
// stage while selected, and freezes it while deselected.
// Assumes sel and ctl_in are synchronous to clk.
module chansel_ctrl_hold #(
    parameter int              CTL_W     = 4,
    parameter logic [CTL_W-1:0] CTL_RESET = 4'b0110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [CTL_W-1:0] ctl_in,
    output logic [CTL_W-1:0] ctl_out
);

    logic [CTL_W-1:0] ctl_q;

    // Capture live controls while selected, hold while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)   ctl_q <= CTL_RESET;
        else if (sel) ctl_q <= ctl_in;
    end

    assign ctl_out = ctl_q;

    a_r1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> ctl_out == $past(ctl_in));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(ctl_out));

endmodule

// File: rtl/chansel_line_arb.sv
// Direction arbiter for one data line.
// In neutral, the first sampled falling edge picks the driving side (host
// wins a tie). The driver's rising edge returns the line to neutral.
// Deselection forces neutral and releases both sides.
// Assumes line levels are synchronous to clk and idle high.
module chansel_line_arb
    import chansel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic host_din,
    input  logic card_din,
    output logic host_dout,
    output logic card_dout
);

    ln_dir_e st_q, st_d;
    logic    h_q, c_q;
    logic    h_fall, c_fall, h_rise, c_rise;

    // Previous levels for edge detection; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= 1'b1;
            c_q <= 1'b1;
        end else begin
            h_q <= host_din;
            c_q <= card_din;
        end
    end

    assign h_fall = h_q & ~host_din;
    assign c_fall = c_q & ~card_din;
    assign h_rise = ~h_q & host_din;
    assign c_rise = ~c_q & card_din;

    // Next direction: claim on first fall, release on driver rise.
    always_comb begin
        st_d = st_q;
        if (!sel) begin
            st_d = LN_IDLE;
        end else begin
            case (st_q)
                LN_IDLE: begin
                    if (h_fall)      st_d = LN_H2C;
                    else if (c_fall) st_d = LN_C2H;
                end
                LN_H2C:  if (h_rise) st_d = LN_IDLE;
                LN_C2H:  if (c_rise) st_d = LN_IDLE;
                default: st_d = LN_IDLE;
            endcase
        end
    end

    // Direction state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LN_IDLE;
        else        st_q <= st_d;
    end

    // Follower side copies the driver; everything else released high.
    assign card_dout = (sel && st_q == LN_H2C) ? host_din : 1'b1;
    assign host_dout = (sel && st_q == LN_C2H) ? card_din : 1'b1;

    a_r9_neutral: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> st_q == LN_IDLE);

    a_r8_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && st_q == LN_IDLE && h_fall && c_fall) |=> st_q == LN_H2C);

    a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_dout == 1'b0 && card_dout == 1'b0));

endmodule

// File: rtl/chansel_status.sv
// Status, ready and deactivation logic.
// Session state comes from the held power commands. Fault and presence
// handling ignores sel; only the output enables follow sel.
// Assumes pres and fault are synchronous to clk.
module chansel_status (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic pwr_a_n,
    input  logic pwr_b_n,
    input  logic pres,
    input  logic fault,
    input  logic rdy_in,
    output logic status_o,
    output logic status_oe,
    output logic ready_o,
    output logic ready_oe,
    output logic deact_req
);

    logic in_session;
    logic deact_q;

    assign in_session = ~pwr_a_n | ~pwr_b_n;

    // Register the deactivation request; sel plays no part.
    always_ff @(posedge clk) begin
        if (!rst_n) deact_q <= 1'b0;
        else        deact_q <= in_session & (fault | ~pres);
    end

    assign deact_req = deact_q;
    assign status_o  = pres & ~(in_session & fault);
    assign status_oe = sel;
    assign ready_o   = rdy_in;
    assign ready_oe  = sel;

    a_r12_deact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_session && fault) |=> deact_req);

    a_r11_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !in_session |-> status_o == pres);

endmodule

// File: rtl/chansel_gate.sv
// Channel select gate top.
// Holds host controls while deselected, parks the data lines and drops the
// status/ready output enables. Fault and presence sensing stay live.
// Assumes all inputs are synchronous to clk.
module chansel_gate #(
    parameter int              CTL_W     = 4,
    parameter int              N_LINES   = 3,
    parameter logic [CTL_W-1:0] CTL_RESET = 4'b0110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic [CTL_W-1:0]   ctl_in,
    output logic [CTL_W-1:0]   ctl_out,
    input  logic [N_LINES-1:0] host_din,
    output logic [N_LINES-1:0] host_dout,
    input  logic [N_LINES-1:0] card_din,
    output logic [N_LINES-1:0] card_dout,
    input  logic               pres,
    input  logic               fault,
    input  logic               rdy_in,
    output logic               status_o,
    output logic               status_oe,
    output logic               ready_o,
    output logic               ready_oe,
    output logic               deact_req
);

    localparam int PWR_A_BIT = 1;
    localparam int PWR_B_BIT = 2;

    chansel_ctrl_hold #(.CTL_W(CTL_W), .CTL_RESET(CTL_RESET)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .ctl_in  (ctl_in),
        .ctl_out (ctl_out)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        chansel_line_arb u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel),
            .host_din  (host_din[i]),
            .card_din  (card_din[i]),
            .host_dout (host_dout[i]),
            .card_dout (card_dout[i])
        );
    end

    chansel_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .pwr_a_n   (ctl_out[PWR_A_BIT]),
        .pwr_b_n   (ctl_out[PWR_B_BIT]),
        .pres      (pres),
        .fault     (fault),
        .rdy_in    (rdy_in),
        .status_o  (status_o),
        .status_oe (status_oe),
        .ready_o   (ready_o),
        .ready_oe  (ready_oe),
        .deact_req (deact_req)
    );

    a_r10_oe: assert property (@(posedge clk) disable iff (!rst_n)
        status_oe == ready_oe);

endmodule

// File: tb/chansel_gate_test.sv
`timescale 1ns/1ps
module chansel_gate_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel;
    logic [3:0] ctl_in;
    logic [3:0] ctl_out;
    logic [2:0] host_din, host_dout, card_din, card_dout;
    logic       pres, fault, rdy_in;
    logic       status_o, status_oe, ready_o, ready_oe, deact_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    chansel_gate uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ctl_in(ctl_in), .ctl_out(ctl_out),
        .host_din(host_din), .host_dout(host_dout),
        .card_din(card_din), .card_dout(card_dout),
        .pres(pres), .fault(fault), .rdy_in(rdy_in),
        .status_o(status_o), .status_oe(status_oe),
        .ready_o(ready_o), .ready_oe(ready_oe), .deact_req(deact_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sel = 1'b1; ctl_in = 4'b1001;
        host_din = '1; card_din = '1; pres = 1'b0; fault = 1'b0; rdy_in = 1'b0;
        step(); step();
        chk("R4 ctl", ctl_out, 4'b0110);
        chk("R4 deact", deact_req, 0);
        chk("R4 lines", {host_dout, card_dout}, 6'h3f);
        rst_n = 1'b1;
        ctl_in = 4'b0110;
        step();
    endtask

    task automatic t_follow();
        sel = 1'b1; ctl_in = 4'b1011; step();
        chk("R1 follow a", ctl_out, 4'b1011);
        ctl_in = 4'b0100; step();
        chk("R1 follow b", ctl_out, 4'b0100);
    endtask

    task automatic t_hold();
        sel = 1'b1; ctl_in = 4'b1101; step();
        sel = 1'b0; ctl_in = 4'b0010; step();
        chk("R2 hold a", ctl_out, 4'b1101);
        ctl_in = 4'b0000; step();
        chk("R2 hold b", ctl_out, 4'b1101);
        sel = 1'b1; ctl_in = 4'b0111; step();
        chk("R3 reselect", ctl_out, 4'b0111);
        ctl_in = 4'b0110; step();
    endtask

    task automatic t_host_drive();
        sel = 1'b1; host_din = '1; card_din = '1; step();
        host_din[0] = 1'b0; step();
        chk("R5 card follows low", card_dout[0], 0);
        chk("R5 host released", host_dout[0], 1);
        host_din[0] = 1'b1; step();
        chk("R7 neutral card", card_dout[0], 1);
        host_din[0] = 1'b0; step(); host_din[0] = 1'b1; step();
    endtask

    task automatic t_card_drive();
        sel = 1'b1; card_din[1] = 1'b0; step();
        chk("R6 host follows low", host_dout[1], 0);
        chk("R6 card released", card_dout[1], 1);
        card_din[1] = 1'b1; step();
        chk("R7 neutral host", host_dout[1], 1);
        host_din[1] = 1'b0; step();
        chk("R7 reclaim by host", card_dout[1], 0);
        host_din[1] = 1'b1; step();
    endtask

    task automatic t_tie();
        host_din[2] = 1'b0; card_din[2] = 1'b0; step();
        chk("R8 host wins card", card_dout[2], 0);
        chk("R8 host wins host", host_dout[2], 1);
        host_din[2] = 1'b1; card_din[2] = 1'b1; step(); step();
    endtask

    task automatic t_desel_lines();
        sel = 1'b1; host_din[0] = 1'b0; step();
        chk("R9 pre transfer", card_dout[0], 0);
        sel = 1'b0; #0.1;
        chk("R9 forced release", card_dout[0], 1);
        step(); step();
        chk("R9 still released", card_dout[0], 1);
        card_din[1] = 1'b0; step();
        chk("R9 fall ignored", host_dout[1], 1);
        sel = 1'b1; step();
        chk("R9 no late claim host", card_dout[0], 1);
        chk("R9 no late claim card", host_dout[1], 1);
        host_din[0] = 1'b1; card_din[1] = 1'b1; step();
    endtask

    task automatic t_status();
        sel = 1'b1; rdy_in = 1'b1; ctl_in = 4'b0110; pres = 1'b1; fault = 1'b1; step();
        chk("R10 oe on", {status_oe, ready_oe, ready_o}, 3'b111);
        chk("R11 outside session", status_o, 1);
        chk("R12 no session", deact_req, 0);
        ctl_in = 4'b0100; fault = 1'b0; step();
        chk("R11 session ok", status_o, 1);
        fault = 1'b1; step();
        chk("R11 session fault", status_o, 0);
        chk("R12 fault deact", deact_req, 1);
        sel = 1'b0; fault = 1'b0; pres = 1'b0; rdy_in = 1'b0; step();
        chk("R10 oe off", {status_oe, ready_oe, ready_o}, 3'b000);
        chk("R12 removal deselected", deact_req, 1);
        pres = 1'b1; step();
        chk("R12 clear", deact_req, 0);
        sel = 1'b1; ctl_in = 4'b0110; step();
    endtask

    initial begin
        t_reset();
        t_follow();
        t_hold();
        t_host_drive();
        t_card_drive();
        t_tie();
        t_desel_lines();
        t_status();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule